// File: doc/BRIEF.md
# Three-Port Fixed-Priority Video Memory Arbiter

The block lets three requesters share one external single-port SRAM that holds video frames. A display scanner reads one word at a time, and each word carries four pixels, so a display refreshing at a 25 MHz pixel rate needs one word every fourth pixel tick. A network-video writer, filled by a processor from received packets, stores pixels. It identifies its target by a line number, a field bit and a word offset within the line, and the block turns these into an SRAM word address. A DMA writer stores the locally captured video and supplies a full word address.

Only one access reaches the SRAM in each cycle, and the order is fixed. The display always wins, because a missed word corrupts the picture. The network writer comes next, so that the steady DMA traffic cannot starve the sparse network packets. The DMA writer is served last. A requester raises its request, holds it together with its address and data, and drops it in the cycle after it sees its grant or acknowledge. A port that was served in one cycle is not considered in the next cycle. This means a request still held at the edge of its own grant is never served twice.

Top module: `vidmem_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, sram_we_n and sram_oe_n are high (inactive) and dsp_gnt, dsp_rvalid, net_ack and dma_ack are low.
- R2: A display request (dsp_req) wins over any network or DMA request that is pending in the same cycle.
- R3: A network request wins over a DMA request when no display request competes.
- R4: At most one of dsp_gnt, net_ack and dma_ack is high in any cycle, and each is high for exactly one cycle per access.
- R5: A request that loses stays pending and is served in a later cycle, in priority order. A port served in cycle n is not served in cycle n+1, even if its request is still high.
- R6: sram_we_n is low only in the cycle in which net_ack or dma_ack is high. In that cycle sram_wdata carries the winning port's data and sram_oe_n is high.
- R7: sram_oe_n is low only in the cycle in which dsp_gnt is high. In that cycle sram_addr equals dsp_addr as sampled at the request, and sram_we_n is high.
- R8: The word on sram_rdata during a display grant cycle appears on dsp_rdata one cycle later, with dsp_rvalid high for exactly that cycle.
- R9: A network write goes to word address NET_BASE + (2*net_line + net_field) * (PIX_PER_LINE / PIX_PER_WORD) + net_offs. With the defaults (NET_BASE 19200, 320 pixels per line, 4 pixels per word) this is 19200 + (2*line+field)*80 + offset.
- R10: A DMA write goes to dma_addr unchanged, with dma_wdata on sram_wdata.
- R11: The grant or acknowledge appears in the cycle after the request is sampled. The SRAM controls for that access are driven in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_req | input | 1 | Display read request |
| dsp_addr | input | ADDR_W | Display word address |
| dsp_gnt | output | 1 | Display access granted; SRAM read this cycle |
| dsp_rvalid | output | 1 | dsp_rdata valid |
| dsp_rdata | output | DATA_W | Registered read word (four pixels) |
| net_req | input | 1 | Network write request |
| net_line | input | LINE_W | Network line number |
| net_field | input | 1 | Network field bit |
| net_offs | input | OFFS_W | Word offset within the line |
| net_wdata | input | DATA_W | Network write word |
| net_ack | output | 1 | Network write performed this cycle |
| dma_req | input | 1 | DMA write request |
| dma_addr | input | ADDR_W | DMA word address |
| dma_wdata | input | DATA_W | DMA write word |
| dma_ack | output | 1 | DMA write performed this cycle |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |

## Verification
Suppose the registered grant were wrong. A second grant or acknowledge would then show up in the very next cycle, either alongside another one or directly after the same port was served. A strobe can also land in a cycle where no matching write or output enable is driven. Suppose instead the address or data registers captured the wrong port. Then sram_addr or sram_wdata would differ from the winning port's values in the acknowledge cycle itself. A fault in the read return register shows on dsp_rdata or dsp_rvalid exactly one cycle after the display grant.

// File: rtl/vidmem_arb_pkg.sv
package vidmem_arb_pkg;

    // Requester slots, in priority order (lowest index wins)
    localparam int unsigned NUM_PORTS = 3;
    localparam int unsigned SLOT_DSP  = 0;
    localparam int unsigned SLOT_NET  = 1;
    localparam int unsigned SLOT_DMA  = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DSP  = 2'd1,
        SRC_NET  = 2'd2,
        SRC_DMA  = 2'd3
    } src_e;

    function automatic src_e onehot_to_src(input logic [NUM_PORTS-1:0] oh);
        src_e s;
        s = SRC_NONE;
        if (oh[SLOT_DSP])      s = SRC_DSP;
        else if (oh[SLOT_NET]) s = SRC_NET;
        else if (oh[SLOT_DMA]) s = SRC_DMA;
        return s;
    endfunction

endpackage

// File: rtl/vidmem_prio_pick.sv
module vidmem_prio_pick #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] block,
    output logic [N-1:0] pick
);
    logic [N-1:0] elig;
    logic [N:0]   taken;

    assign elig     = req & ~block;
    assign taken[0] = 1'b0;

    // Ripple chain: slot i wins when it is eligible and no lower slot won
    for (genvar i = 0; i < N; i++) begin : g_slot
        assign pick[i]    = elig[i] & ~taken[i];
        assign taken[i+1] = taken[i] | elig[i];
    end

endmodule

// File: rtl/vidmem_net_addr.sv
module vidmem_net_addr #(
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned LINE_W        = 8,
    parameter int unsigned OFFS_W        = 7,
    parameter int unsigned WORDS_PER_ROW = 80,
    parameter int unsigned NET_BASE      = 19200
) (
    input  logic [LINE_W-1:0] line,
    input  logic              field,
    input  logic [OFFS_W-1:0] offs,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(NET_BASE);
    localparam logic [ADDR_W-1:0] ROW_A  = ADDR_W'(WORDS_PER_ROW);

    logic [ADDR_W-1:0] row;

    always_comb begin
        // Interleaved frame row: two fields per line number
        row  = ADDR_W'({line, field});
        addr = BASE_A + row * ROW_A + ADDR_W'(offs);
    end

endmodule

// File: rtl/vidmem_rd_return.sv
module vidmem_rd_return #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } ret_t;

    ret_t ret_d, ret_q;

    always_comb begin
        ret_d     = ret_q;
        ret_d.vld = capture;
        if (capture) begin
            ret_d.dat = sram_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else begin
            ret_q <= ret_d;
        end
    end

    assign rvalid = ret_q.vld;
    assign rdata  = ret_q.dat;

    // R8: read word returned one cycle after the grant
    p_valid_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> rvalid);
    p_data_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (rdata == $past(sram_rdata)));
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> !rvalid);

endmodule

// File: rtl/vidmem_arbiter.sv
module vidmem_arbiter
    import vidmem_arb_pkg::*;
#(
    parameter int unsigned ADDR_W       = 18,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned LINE_W       = 8,
    parameter int unsigned PIX_PER_LINE = 320,
    parameter int unsigned PIX_PER_WORD = 4,
    parameter int unsigned NET_BASE     = 19200,
    localparam int unsigned WORDS_PER_ROW = PIX_PER_LINE / PIX_PER_WORD,
    localparam int unsigned OFFS_W        = $clog2(WORDS_PER_ROW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dsp_req,
    input  logic [ADDR_W-1:0] dsp_addr,
    output logic              dsp_gnt,
    output logic              dsp_rvalid,
    output logic [DATA_W-1:0] dsp_rdata,
    input  logic              net_req,
    input  logic [LINE_W-1:0] net_line,
    input  logic              net_field,
    input  logic [OFFS_W-1:0] net_offs,
    input  logic [DATA_W-1:0] net_wdata,
    output logic              net_ack,
    input  logic              dma_req,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic              dma_ack,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    typedef struct packed {
        logic [NUM_PORTS-1:0] gnt;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    wdata;
        logic                 we_n;
        logic                 oe_n;
    } bus_t;

    bus_t st_d, st_q;

    logic [NUM_PORTS-1:0] req_vec;
    logic [NUM_PORTS-1:0] pick;
    logic [ADDR_W-1:0]    net_addr;
    src_e                 win;

    assign req_vec[SLOT_DSP] = dsp_req;
    assign req_vec[SLOT_NET] = net_req;
    assign req_vec[SLOT_DMA] = dma_req;

    // A port served last cycle is blocked so a held request is not served twice
    vidmem_prio_pick #(.N(NUM_PORTS)) u_pick (
        .req   (req_vec),
        .block (st_q.gnt),
        .pick  (pick)
    );

    vidmem_net_addr #(
        .ADDR_W        (ADDR_W),
        .LINE_W        (LINE_W),
        .OFFS_W        (OFFS_W),
        .WORDS_PER_ROW (WORDS_PER_ROW),
        .NET_BASE      (NET_BASE)
    ) u_net_addr (
        .line  (net_line),
        .field (net_field),
        .offs  (net_offs),
        .addr  (net_addr)
    );

    always_comb begin
        win        = onehot_to_src(pick);
        st_d       = st_q;
        st_d.gnt   = pick;
        st_d.we_n  = 1'b1;
        st_d.oe_n  = 1'b1;
        unique case (win)
            SRC_DSP: begin
                st_d.addr = dsp_addr;
                st_d.oe_n = 1'b0;
            end
            SRC_NET: begin
                st_d.addr  = net_addr;
                st_d.wdata = net_wdata;
                st_d.we_n  = 1'b0;
            end
            SRC_DMA: begin
                st_d.addr  = dma_addr;
                st_d.wdata = dma_wdata;
                st_d.we_n  = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gnt   <= '0;
            st_q.addr  <= '0;
            st_q.wdata <= '0;
            st_q.we_n  <= 1'b1;
            st_q.oe_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dsp_gnt    = st_q.gnt[SLOT_DSP];
    assign net_ack    = st_q.gnt[SLOT_NET];
    assign dma_ack    = st_q.gnt[SLOT_DMA];
    assign sram_addr  = st_q.addr;
    assign sram_wdata = st_q.wdata;
    assign sram_we_n  = st_q.we_n;
    assign sram_oe_n  = st_q.oe_n;

    vidmem_rd_return #(.DATA_W(DATA_W)) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (dsp_gnt),
        .sram_rdata (sram_rdata),
        .rvalid     (dsp_rvalid),
        .rdata      (dsp_rdata)
    );

    // R4: one access per cycle
    p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dsp_gnt, net_ack, dma_ack}));
    // R5: no port served in two consecutive cycles
    p_no_regrant_dsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_gnt |=> !dsp_gnt);
    p_no_regrant_net_r5: assert property (@(posedge clk) disable iff (!rst_n)
        net_ack |=> !net_ack);
    p_no_regrant_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack |=> !dma_ack);
    // R2: an eligible display request is always served next
    p_dsp_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_req && !dsp_gnt) |=> dsp_gnt);
    // R3: network beats DMA when the display is silent
    p_net_over_dma_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (net_req && !net_ack && !dsp_req) |=> net_ack);
    // R6: write strobe only for write ports
    p_we_only_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> ((net_ack || dma_ack) && sram_oe_n));
    // R7: output enable only for display reads
    p_oe_only_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (dsp_gnt && sram_we_n));
    p_ack_has_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (net_ack || dma_ack) |-> !sram_we_n);
    // R10: DMA address passes unchanged
    p_dma_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && !dsp_req && !net_req) |=>
        (dma_ack && sram_addr == $past(dma_addr)));

endmodule

// File: tb/vidmem_arbiter_tb_top.sv
module vidmem_arbiter_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  ADDR_W = 18;
    localparam int  DATA_W = 16;
    localparam int  LINE_W = 8;
    localparam int  OFFS_W = 7;
    localparam int  N_VEC  = 8;
    // Each entry: {req dma,net,dsp ; expected grant dma,net,dsp}
    localparam logic [5:0] VEC [N_VEC] = '{
        6'b001_001, 6'b010_010, 6'b100_100, 6'b011_001,
        6'b110_010, 6'b101_001, 6'b111_001, 6'b000_000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dsp_req = 1'b0, net_req = 1'b0, dma_req = 1'b0;
    logic [ADDR_W-1:0] dsp_addr = '0, dma_addr = '0;
    logic [LINE_W-1:0] net_line = '0;
    logic              net_field = 1'b0;
    logic [OFFS_W-1:0] net_offs = '0;
    logic [DATA_W-1:0] net_wdata = '0, dma_wdata = '0;
    logic dsp_gnt, dsp_rvalid, net_ack, dma_ack, sram_we_n, sram_oe_n;
    logic [DATA_W-1:0] dsp_rdata, sram_wdata, sram_rdata;
    logic [ADDR_W-1:0] sram_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural memory: read word is a fixed function of the address
    assign sram_rdata = sram_oe_n ? '0 : (sram_addr[DATA_W-1:0] ^ 16'h5A3C);

    vidmem_arbiter dut_i (
        .clk(clk), .rst_n(rst_n),
        .dsp_req(dsp_req), .dsp_addr(dsp_addr), .dsp_gnt(dsp_gnt),
        .dsp_rvalid(dsp_rvalid), .dsp_rdata(dsp_rdata),
        .net_req(net_req), .net_line(net_line), .net_field(net_field),
        .net_offs(net_offs), .net_wdata(net_wdata), .net_ack(net_ack),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_ack(dma_ack),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] strobes();
        return {dma_ack, net_ack, dsp_gnt};
    endfunction

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        idle(2);
        chk("R1 strobes in reset", 32'(strobes()), 0);
        chk("R1 we_n/oe_n in reset", {30'd0, sram_we_n, sram_oe_n}, 32'h3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobes after reset", {28'd0, dsp_rvalid, strobes()}, 0);
        chk("R1 we_n/oe_n after reset", {30'd0, sram_we_n, sram_oe_n}, 32'h3);

        // Table walk: R2 R3 R4 R11 priority under one-cycle request patterns
        dsp_addr = 18'h00123; dma_addr = 18'h2ABCD; dma_wdata = 16'hD00D;
        net_line = 8'd5; net_field = 1'b1; net_offs = 7'd3; net_wdata = 16'hBEEF;
        for (int v = 0; v < N_VEC; v++) begin
            {dma_req, net_req, dsp_req} = VEC[v][5:3];
            @(negedge clk);
            chk($sformatf("R2/R3/R4 vec%0d grant", v), 32'(strobes()), 32'(VEC[v][2:0]));
            if (VEC[v][1]) begin
                // R9: 19200 + (2*5+1)*80 + 3 = 20083
                chk("R9 net address", 32'(sram_addr), 32'd20083);
                chk("R6 net data/we", {15'd0, sram_we_n, sram_wdata}, {16'd0, 16'hBEEF});
            end
            if (VEC[v][2]) begin
                chk("R10 dma address", 32'(sram_addr), 32'h2ABCD);
                chk("R6 dma data/we", {15'd0, sram_we_n, sram_wdata}, {16'd0, 16'hD00D});
            end
            if (VEC[v][0]) begin
                chk("R7 dsp addr/oe", {13'd0, sram_we_n, sram_oe_n, sram_addr}, {14'd2, 18'h00123});
            end
            {dma_req, net_req, dsp_req} = 3'b000;
            @(negedge clk);
            chk($sformatf("R4 vec%0d pulse ends", v), 32'(strobes()), 0);
            chk($sformatf("R8 vec%0d rvalid", v), 32'(dsp_rvalid), 32'(VEC[v][0]));
            if (VEC[v][0]) chk("R8 read data", 32'(dsp_rdata), 32'(16'h0123 ^ 16'h5A3C));
            idle(1);
        end

        // R5: all three held until their own strobe, served in order
        {dma_req, net_req, dsp_req} = 3'b111;
        @(negedge clk);
        chk("R5 first served dsp", 32'(strobes()), 32'b001);
        dsp_req = 1'b0;
        @(negedge clk);
        chk("R5 second served net", 32'(strobes()), 32'b010);
        net_req = 1'b0;
        @(negedge clk);
        chk("R5 third served dma", 32'(strobes()), 32'b100);
        dma_req = 1'b0;
        idle(2);
        chk("R5 idle after drain", {29'd0, strobes()}, 0);
        chk("R6/R7 bus idle", {30'd0, sram_we_n, sram_oe_n}, 32'h3);

        // R5: display held continuously alternates with network
        dsp_req = 1'b1; net_req = 1'b1;
        @(negedge clk);
        chk("R5 dsp held c1", 32'(strobes()), 32'b001);
        @(negedge clk);
        chk("R5 dsp masked c2", 32'(strobes()), 32'b010);
        net_req = 1'b0;
        @(negedge clk);
        chk("R5 dsp again c3", 32'(strobes()), 32'b001);
        @(negedge clk);
        chk("R5 no back-to-back c4", 32'(strobes()), 32'b000);
        dsp_req = 1'b0;
        idle(2);

        // R9: other line/field/offset corner: line 239 field 0 offset 79
        net_line = 8'd239; net_field = 1'b0; net_offs = 7'd79; net_req = 1'b1;
        @(negedge clk);
        net_req = 1'b0;
        chk("R9 net address max", 32'(sram_addr), 32'(19200 + 478 * 80 + 79));
        idle(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule